// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block sits between a set of peripheral interrupt lines and a CPU core. Ten request vectors come in, each with a pending flag, an enable bit and a two-bit priority code chosen by software. The block selects one request to offer the CPU. It raises an interrupt line together with the entry address of the chosen vector and the priority tier of that vector.

Nesting follows the priority tiers. The block keeps one in-service bit per tier. Only a request from a tier strictly above the highest tier now in service may interrupt the running code. When the CPU takes the offer, the tier of the vector is marked in service. A return strobe from the CPU clears the highest marked tier. The selection result passes through a register, so the CPU never sees the address change while the request line is high.

Top module: `tri_lvl_intc`

## Requirements
- R1: Vector i (0 to 9) is offered at entry address 0x03 + 8*i, so the addresses run 0x03, 0x0B, ... 0x4B.
- R2: Vector i takes its tier from bits [2i+1:2i] of `prio_code_i`. Code 00 is low, 01 is high, and 10 or 11 is highest. `offer_tier_o` reports the tier as 0 (low), 1 (high) or 2 (highest).
- R3: A vector is a candidate only while its pending bit and its enable bit are both 1 and the global enable is 1.
- R4: When candidates exist in different tiers, the candidate in the highest tier is offered.
- R5: Among candidates in the same tier, the one with the lowest vector index (smallest address) is offered.
- R6: A candidate whose tier is equal to or below the highest in-service tier is not offered. With nothing in service, every tier, low included, may be offered.
- R7: `irq_o` rises two clock edges after a candidate first qualifies. `vec_addr_o` already holds that vector's address one cycle before `irq_o` rises, and it does not change while `irq_o` stays high.
- R8: `ack_i` sampled while `irq_o` is high sets bit t of `in_service_o` (t = offered tier) and drops `irq_o` at the same edge. `ack_i` while `irq_o` is low has no effect.
- R9: `reti_i` clears the highest set bit of `in_service_o`. When no bit is set, `reti_i` has no effect.
- R10: A synchronous active-low reset clears `in_service_o` and `irq_o`.
- R11: When the global enable goes low, `irq_o` is low after the next clock edge, and it stays low while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| glb_en_i | input | 1 | Global interrupt enable |
| pend_i | input | 10 | Pending flag per vector |
| vec_en_i | input | 10 | Enable bit per vector |
| prio_code_i | input | 20 | Two-bit tier code per vector |
| ack_i | input | 1 | CPU takes the offered vector |
| reti_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 8 | Entry address of the offered vector |
| offer_tier_o | output | 2 | Tier of the offered vector |
| in_service_o | output | 3 | In-service bit per tier (bit 0 low, bit 2 highest) |

## Verification
The assertions assume that `ack_i` and `reti_i` are one-cycle strobes and that they are never raised in the same cycle. They also assume that a return is issued only for a handler that was acknowledged. The bench drives each strobe for exactly one cycle and changes inputs only at falling edges. It keeps a return separate from any acknowledge, and it issues the extra return on an empty stack on purpose, to exercise the no-effect case.

// File: rtl/intc_pkg.sv
// Shared constants and helpers for the three-level interrupt controller.
// Assumes tier codes are two bits wide; codes 10 and 11 both mean highest.
package intc_pkg;

    localparam int NUM_TIER = 3;
    localparam int TIER_W   = 2;

    typedef enum logic [TIER_W-1:0] {
        TIER_LOW  = 2'd0,
        TIER_HIGH = 2'd1,
        TIER_TOP  = 2'd2
    } tier_e;

    // Map a raw two-bit code to a normalized tier number 0..2.
    function automatic logic [TIER_W-1:0] norm_tier(input logic [TIER_W-1:0] code);
        return code[1] ? TIER_TOP : (code[0] ? TIER_HIGH : TIER_LOW);
    endfunction

    // Rank of a tier: 1..3, so that rank 0 can stand for "idle".
    function automatic logic [TIER_W-1:0] tier_rank(input logic [TIER_W-1:0] tier);
        return tier + 2'd1;
    endfunction

endpackage

// File: rtl/intc_arbiter.sv
// Combinational selection of the vector to offer.
// A vector is eligible when its request is set and its tier ranks above the
// current in-service rank. The highest eligible tier wins. Inside that tier,
// the lowest index wins. Assumes cur_rank_i is 0 when nothing is in service.
module intc_arbiter #(
    parameter int NUM_VEC = 10,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]                    req_i,
    input  logic [intc_pkg::TIER_W*NUM_VEC-1:0]   code_i,
    input  logic [intc_pkg::TIER_W-1:0]           cur_rank_i,
    output logic                                  win_vld_o,
    output logic [IDX_W-1:0]                      win_idx_o,
    output logic [intc_pkg::TIER_W-1:0]           win_tier_o
);
    import intc_pkg::*;

    logic [TIER_W-1:0]  vec_tier [NUM_VEC];
    logic [NUM_VEC-1:0] eligible;
    logic [NUM_VEC-1:0] tier_hit [NUM_TIER];
    logic [NUM_VEC-1:0] chosen_set;

    // Decode each vector's tier and test it against the in-service rank.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign vec_tier[v] = norm_tier(code_i[TIER_W*v +: TIER_W]);
        assign eligible[v] = req_i[v] && (tier_rank(vec_tier[v]) > cur_rank_i);
    end

    // Sort eligible vectors into one bit set per tier.
    always_comb begin
        for (int t = 0; t < NUM_TIER; t++) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                tier_hit[t][v] = eligible[v] && (vec_tier[v] == TIER_W'(t));
            end
        end
    end

    // Pick the highest tier that holds at least one eligible vector.
    always_comb begin
        win_vld_o  = 1'b0;
        win_tier_o = TIER_LOW;
        chosen_set = '0;
        for (int t = 0; t < NUM_TIER; t++) begin
            if (|tier_hit[t]) begin
                win_vld_o  = 1'b1;
                win_tier_o = TIER_W'(t);
                chosen_set = tier_hit[t];
            end
        end
    end

    // Within the chosen tier, keep the lowest set index.
    always_comb begin
        win_idx_o = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (chosen_set[v]) begin
                win_idx_o = IDX_W'(v);
            end
        end
    end

endmodule

// File: rtl/intc_inservice.sv
// In-service tier stack, kept as one bit per tier.
// The current rank is the index of the highest set bit plus one, or 0 when idle.
// push sets the bit of the given tier. pop clears the highest set bit.
// Assumes push only carries a tier above the current one.
module intc_inservice #(
    parameter int NUM_TIER = intc_pkg::NUM_TIER
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [intc_pkg::TIER_W-1:0] push_tier_i,
    input  logic                        pop_i,
    output logic [NUM_TIER-1:0]         mask_o,
    output logic [intc_pkg::TIER_W-1:0] cur_rank_o
);
    import intc_pkg::*;

    logic [NUM_TIER-1:0] mask_q;
    logic [NUM_TIER-1:0] mask_d;
    logic [NUM_TIER-1:0] top_oh;

    // One-hot of the highest set in-service bit.
    always_comb begin
        top_oh = '0;
        for (int t = 0; t < NUM_TIER; t++) begin
            if (mask_q[t]) begin
                top_oh    = '0;
                top_oh[t] = 1'b1;
            end
        end
    end

    // Rank of the current in-service tier.
    always_comb begin
        cur_rank_o = '0;
        for (int t = 0; t < NUM_TIER; t++) begin
            if (mask_q[t]) begin
                cur_rank_o = TIER_W'(t + 1);
            end
        end
    end

    // Next mask: clear the top bit on pop, then set the pushed tier.
    always_comb begin
        mask_d = mask_q;
        if (pop_i) begin
            mask_d = mask_d & ~top_oh;
        end
        if (push_i) begin
            for (int t = 0; t < NUM_TIER; t++) begin
                if (push_tier_i == TIER_W'(t)) begin
                    mask_d[t] = 1'b1;
                end
            end
        end
    end

    // Mask register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/intc_offer.sv
// Registered offer stage. It holds the arbiter's choice for one cycle and
// raises the request only when the choice is the same on two edges in a row,
// so the address is stable before and during the request.
// take_i (an accepted acknowledge) withdraws the offer at once.
module intc_offer #(
    parameter int NUM_VEC    = 10,
    parameter int IDX_W      = $clog2(NUM_VEC),
    parameter int ADDR_W     = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_vld_i,
    input  logic [IDX_W-1:0]            win_idx_i,
    input  logic [intc_pkg::TIER_W-1:0] win_tier_i,
    input  logic                        take_i,
    output logic                        irq_o,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [intc_pkg::TIER_W-1:0] tier_o
);
    import intc_pkg::*;

    logic               held_vld;
    logic [IDX_W-1:0]   held_idx;
    logic [TIER_W-1:0]  held_tier;
    logic               irq_q;
    logic               same_choice;

    // The new choice matches the one already held.
    assign same_choice = win_vld_i && held_vld &&
                         (win_idx_i == held_idx) && (win_tier_i == held_tier);

    // Hold the choice and qualify the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld  <= 1'b0;
            held_idx  <= '0;
            held_tier <= '0;
            irq_q     <= 1'b0;
        end else if (take_i) begin
            held_vld  <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            held_vld  <= win_vld_i;
            held_idx  <= win_idx_i;
            held_tier <= win_tier_i;
            irq_q     <= same_choice;
        end
    end

    // Entry address computed from the held index.
    assign addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(held_idx) * ADDR_W'(VEC_STRIDE);
    assign tier_o = held_tier;
    assign irq_o  = irq_q;

endmodule

// File: rtl/tri_lvl_intc.sv
// Top of the three-level vectored interrupt controller.
// Gates requests with the enables, arbitrates them against the in-service
// tier, and offers one vector to the CPU through a registered stage.
// Assumes ack_i and reti_i are single-cycle strobes from the CPU.
module tri_lvl_intc #(
    parameter int NUM_VEC    = 10,
    parameter int ADDR_W     = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en_i,
    input  logic [NUM_VEC-1:0]        pend_i,
    input  logic [NUM_VEC-1:0]        vec_en_i,
    input  logic [2*NUM_VEC-1:0]      prio_code_i,
    input  logic                      ack_i,
    input  logic                      reti_i,
    output logic                      irq_o,
    output logic [ADDR_W-1:0]         vec_addr_o,
    output logic [1:0]                offer_tier_o,
    output logic [2:0]                in_service_o
);
    import intc_pkg::*;

    localparam int IDX_W = $clog2(NUM_VEC);

    logic [NUM_VEC-1:0] req;
    logic [TIER_W-1:0]  cur_rank;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;
    logic [TIER_W-1:0]  win_tier;
    logic               take;

    // Qualify each pending flag with its own and the global enable.
    assign req  = pend_i & vec_en_i & {NUM_VEC{glb_en_i}};
    // An acknowledge counts only while an offer is up.
    assign take = ack_i && irq_o;

    intc_arbiter #(
        .NUM_VEC (NUM_VEC),
        .IDX_W   (IDX_W)
    ) arb_i (
        .req_i      (req),
        .code_i     (prio_code_i),
        .cur_rank_i (cur_rank),
        .win_vld_o  (win_vld),
        .win_idx_o  (win_idx),
        .win_tier_o (win_tier)
    );

    intc_offer #(
        .NUM_VEC    (NUM_VEC),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) offer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_vld_i  (win_vld),
        .win_idx_i  (win_idx),
        .win_tier_i (win_tier),
        .take_i     (take),
        .irq_o      (irq_o),
        .addr_o     (vec_addr_o),
        .tier_o     (offer_tier_o)
    );

    intc_inservice #(
        .NUM_TIER (NUM_TIER)
    ) isr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take),
        .push_tier_i (offer_tier_o),
        .pop_i       (reti_i),
        .mask_o      (in_service_o),
        .cur_rank_o  (cur_rank)
    );

endmodule

// File: rtl/tri_lvl_intc_chk.sv
// Property checker for tri_lvl_intc, attached with bind below.
// Assumes ack_i and reti_i never arrive in the same cycle.
module tri_lvl_intc_chk #(
    parameter int ADDR_W     = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en_i,
    input logic              ack_i,
    input logic              reti_i,
    input logic              irq_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [1:0]        offer_tier_o,
    input logic [2:0]        in_service_o
);

    // R1
    addr_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (((int'(vec_addr_o) - VEC_BASE) % VEC_STRIDE) == 0));

    // R6
    tier_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((in_service_o >> offer_tier_o) == 3'b000));

    // R7
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $stable(vec_addr_o));

    // R8
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !reti_i) |=> (in_service_o[$past(offer_tier_o)] && !irq_o));

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !reti_i) |=> $stable(in_service_o));

    // R9
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && (in_service_o != 3'b000)) |=>
        ($countones(in_service_o) == $countones($past(in_service_o)) - 1));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (in_service_o == 3'b000 && !irq_o));

    // R11
    glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(glb_en_i));

endmodule

bind tri_lvl_intc tri_lvl_intc_chk #(
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_en_i     (glb_en_i),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .irq_o        (irq_o),
    .vec_addr_o   (vec_addr_o),
    .offer_tier_o (offer_tier_o),
    .in_service_o (in_service_o)
);

// File: tb/tri_lvl_intc_tb_top.sv
`timescale 1ns/1ps
module tri_lvl_intc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b1;
    logic [9:0]  pend = '0;
    logic [9:0]  vec_en = '1;
    logic [19:0] code = '0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq;
    logic [7:0]  addr;
    logic [1:0]  tier;
    logic [2:0]  isr;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tri_lvl_intc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .glb_en_i     (glb_en),
        .pend_i       (pend),
        .vec_en_i     (vec_en),
        .prio_code_i  (code),
        .ack_i        (ack),
        .reti_i       (reti),
        .irq_o        (irq),
        .vec_addr_o   (addr),
        .offer_tier_o (tier),
        .in_service_o (isr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_code(input int v, input logic [1:0] c);
        code[2*v +: 2] = c;
    endtask

    task automatic quiet();
        pend = '0;
        step(3);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        step(1);
        reti = 1'b0;
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        pend  = 10'h3FF;
        step(3);
        chk("R10 irq in reset", irq, 0);
        chk("R10 mask in reset", isr, 0);
        pend  = '0;
        rst_n = 1'b1;
        step(1);
    endtask

    // R1, R7: each vector alone, address and request timing
    task automatic t_addr();
        code = '0;
        for (int v = 0; v < 10; v++) begin
            pend = 10'(1) << v;
            step(1);
            chk("R7 irq low one edge after request", irq, 0);
            chk("R7 address ahead of irq", addr, 3 + 8 * v);
            step(1);
            chk("R7 irq high two edges after request", irq, 1);
            chk("R1 vector address", addr, 3 + 8 * v);
            quiet();
        end
    endtask

    // R2, R4: higher tier wins
    task automatic t_tier();
        code = '0;
        set_code(7, 2'b11);
        set_code(1, 2'b01);
        set_code(0, 2'b00);
        pend = 10'b0010000011;
        step(2);
        chk("R4 highest tier wins", addr, 8'h3B);
        chk("R2 code 11 is highest", tier, 2);
        quiet();
        pend = 10'b0000000011;
        step(2);
        chk("R4 high beats low", addr, 8'h0B);
        chk("R2 code 01 is high", tier, 1);
        quiet();
        set_code(4, 2'b10);
        pend = 10'b0000010001;
        step(2);
        chk("R2 code 10 is highest", tier, 2);
        chk("R4 tier beats index", addr, 8'h23);
        quiet();
    endtask

    // R5: tie in a tier goes to the lowest index
    task automatic t_tie();
        code = {10{2'b01}};
        pend = 10'b0001010100;
        step(2);
        chk("R5 lowest index in high tier", addr, 8'h13);
        quiet();
        code = '0;
        pend = 10'b1000100000;
        step(2);
        chk("R5 lowest index in low tier", addr, 8'h2B);
        quiet();
    endtask

    // R3, R11: enables gate requests
    task automatic t_gate();
        code = '0;
        vec_en = 10'h3F7;
        pend = 10'b0000001000;
        step(3);
        chk("R3 masked vector not offered", irq, 0);
        vec_en = '1;
        glb_en = 1'b0;
        step(3);
        chk("R11 global off blocks request", irq, 0);
        glb_en = 1'b1;
        step(2);
        chk("R3 enabled vector offered", irq, 1);
        glb_en = 1'b0;
        step(1);
        chk("R11 irq drops one edge after global off", irq, 0);
        step(2);
        chk("R11 stays low while off", irq, 0);
        glb_en = 1'b1;
        quiet();
    endtask

    // R6, R8, R9: nesting by tier
    task automatic t_nest();
        code = '0;
        pend = 10'b0000100000;
        step(2);
        chk("R6 low accepted when idle", irq, 1);
        pulse_ack();
        chk("R8 ack sets low bit", isr, 3'b001);
        chk("R8 irq drops on ack", irq, 0);
        pend = 10'b0000101000;
        step(3);
        chk("R6 equal tier not offered", irq, 0);
        set_code(8, 2'b01);
        pend = 10'b0100101000;
        step(2);
        chk("R6 higher tier preempts", irq, 1);
        chk("R6 preempting address", addr, 8'h43);
        pulse_ack();
        chk("R8 ack sets high bit", isr, 3'b011);
        set_code(0, 2'b01);
        pend = 10'b0100101001;
        step(3);
        chk("R6 equal high tier blocked", irq, 0);
        pulse_reti();
        chk("R9 return clears top bit", isr, 3'b001);
        step(2);
        chk("R5 after return lowest high index", addr, 8'h03);
        chk("R6 high offered again", irq, 1);
        quiet();
        pulse_reti();
        chk("R9 return clears last bit", isr, 3'b000);
        pulse_reti();
        chk("R9 return on empty has no effect", isr, 3'b000);
        pulse_ack();
        chk("R8 ack without irq ignored", isr, 3'b000);
        chk("R8 ack without irq keeps irq low", irq, 0);
    endtask

    // R10: reset during service
    task automatic t_reset_mid();
        code = '0;
        set_code(2, 2'b10);
        pend = 10'b0000000100;
        step(2);
        pulse_ack();
        chk("R8 ack sets highest bit", isr, 3'b100);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk("R10 reset clears mask", isr, 3'b000);
        chk("R10 reset clears irq", irq, 0);
        quiet();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_addr();
        t_tier();
        t_tie();
        t_gate();
        t_nest();
        t_reset_mid();
        report();
    end

    initial begin
        #400000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        report();
    end

endmodule